// File: doc/BRIEF.md
# System Control Register File

This block is a memory-mapped bank of general-purpose 32-bit control and status words for a small SoC. A bus master reaches it through a single-cycle request port: a valid strobe, a write enable, a 12-bit byte address, 32-bit write data, and registered 32-bit read data. The bank is 512 words deep and sits in a 4 KB window. The upper half of that window holds no storage. Any access there is dropped and flagged, except for one command address that is decoded for writes only.

A write to the command address asks the rest of the chip to reset or to power down. The block only raises a one-cycle request. The logic that acts on the request lies outside this block. Three status addresses always read back with bits 29 and 28 set, whatever their stored contents. The storage is an inferred synchronous RAM. After every reset a sequencer walks the whole bank, writes the reset value of each word, and holds a busy flag high until it has finished.

Top module: `sysctl_regs`

## Requirements
- R1: Starting from the first clock edge after `rst_n` is released, `init_busy` stays high for exactly 512 cycles and then stays low until the next reset. After that, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other word holds zero. A second reset restores these values.
- R2: While `init_busy` is high, bus requests have no effect. Nothing is stored, no request or bad-access pulse is produced, and `bus_rdata` holds its value.
- R3: A write with a word index below 512 stores all 32 bits. A read returns the stored word on `bus_rdata` in the cycle after the request, and `bus_rdata` then holds that value until the next accepted read. After reset, `bus_rdata` is zero.
- R4: The word index is address bits 11:2. Address bits 1:0 do not select storage, so byte address 0x013 reaches the same word as 0x010.
- R5: A read at exactly byte address 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. The stored value is not changed. A read of the same word at any other byte address (for example 0x101) returns the raw contents.
- R6: A write at exactly byte address 0xF00 with data 1 or 2 sets `reset_req` high in the following cycle.
- R7: A write at exactly byte address 0xF00 with data 3 sets `shutdown_req` high in the following cycle.
- R8: A write at exactly byte address 0xF00 with any other data raises no request. No command write is stored, and no command write pulses `bad_access`. Writes at other addresses, including 0xF01 and 0xF04, are never decoded as commands.
- R9: Any accepted access with a word index of 512 or more, other than a write at 0xF00, pulses `bad_access` in the following cycle. Such a read returns zero, and such a write changes no stored word.
- R10: `reset_req` and `shutdown_req` are registered pulses. Each stays high for one cycle per command write, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| init_busy | output | 1 | High while the reset sequencer fills the bank |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| bad_access | output | 1 | One-cycle flag for an access with no storage behind it |

## Verification
The assertions check these properties on every cycle:
- each request pulse is caused by a matching command write one cycle earlier;
- the two requests are never high together;
- the busy phase is silent and never returns before a reset;
- a read above the bank returns zero;
- the three status addresses return bits 29:28 set;
- read data stays stable when no read is accepted.

Only the bench scenarios show the rest:
- which reset value lands in which word;
- whether a write reaches exactly one word, including the 0x013 to 0x010 alias and the missing aliasing above index 511;
- the exact 512-cycle length of the busy phase;
- the command codes that must stay silent.

// File: rtl/sysctl_pkg.sv
// Package: shared constants, command encoding and the reset-value function
// for the system control register file.
// Assumes a 32-bit data path and byte addresses compared as 32-bit values.
package sysctl_pkg;

    localparam int unsigned    DATA_W      = 32;
    localparam logic [31:0]    CMD_ADDR    = 32'h0000_0F00;
    localparam logic [31:0]    FORCE_MASK  = 32'h3000_0000;
    localparam int unsigned    N_STATUS    = 3;
    localparam logic [31:0]    STATUS_ADDR [N_STATUS] = '{32'h100, 32'h108, 32'h10C};

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_e;

    // Maps command write data to the request it raises.
    function automatic cmd_e decode_cmd(input logic [31:0] data);
        case (data)
            32'd1, 32'd2: decode_cmd = CMD_RESET;
            32'd3:        decode_cmd = CMD_SHUTDOWN;
            default:      decode_cmd = CMD_NONE;
        endcase
    endfunction

    // Reset value of the word at a given index.
    function automatic logic [31:0] init_word(input logic [31:0] idx);
        case (idx)
            32'h40:  init_word = 32'h05F2_0121;
            32'h41:  init_word = 32'h0000_0002;
            32'h42:  init_word = 32'h05F3_0121;
            32'h43:  init_word = 32'h05F4_0121;
            default: init_word = 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
// Module: sysctl_addr_decode
// Purely combinational decode of a byte address. It reports whether the
// address has storage behind it, the word pointer into the bank, whether it
// is the command address, and whether it is one of the forced status
// addresses.
// Assumes ADDR_W >= PTR_W + 2 and ADDR_W <= 32.
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned PTR_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [PTR_W-1:0]  word_ptr,
    output logic              is_cmd,
    output logic              is_status
);

    logic [31:0] addr_ext;

    // Widen the address for comparison with the package constants.
    always_comb addr_ext = 32'(addr);

    // Decide whether the address has storage, and extract the word pointer.
    always_comb begin
        in_range = (32'(addr[ADDR_W-1:2]) < NUM_WORDS);
        word_ptr = addr[PTR_W+1:2];
        is_cmd   = (addr_ext == CMD_ADDR);
    end

    // Match the exact byte addresses whose reads are forced.
    always_comb begin
        is_status = 1'b0;
        for (int i = 0; i < int'(N_STATUS); i++) begin
            if (addr_ext == STATUS_ADDR[i]) is_status = 1'b1;
        end
    end

endmodule

// File: rtl/sysctl_init_seq.sv
// Module: sysctl_init_seq
// After reset, steps a pointer through every word of the bank, once per
// cycle, and supplies each word's reset value. busy stays high until the
// last word has been written.
// Assumes NUM_WORDS is a power of two, so the pointer wraps naturally.
module sysctl_init_seq
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned PTR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              busy,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] value
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS - 1);

    // Advance the fill pointer and clear busy after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) busy <= 1'b0;
        end
    end

    // Reset value for the word currently addressed.
    always_comb value = init_word(32'(ptr));

endmodule

// File: rtl/sysctl_word_ram.sv
// Module: sysctl_word_ram
// Single-port synchronous RAM with a registered read. Only the read register
// is reset; the array itself is left to the initialisation sequencer.
// Assumes at most one access per cycle, so there is no read-during-write case.
module sysctl_word_ram #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    // Registered read port; it holds its value when no read occurs.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (en && !we)  rdata <= mem[addr];
    end

endmodule

// File: rtl/sysctl_regs.sv
// Module: sysctl_regs (top)
// System control register file. It has a 512-word bank in a 4 KB byte
// window, a command address that raises reset and shutdown requests,
// status addresses that read back with bits 29:28 forced, and a bad-access
// flag for the unbacked upper window. The bank is filled with reset values
// by a sequencer after each reset; bus traffic is ignored while it runs.
// Assumes a single-cycle bus with one access per cycle, full-word writes,
// and no wait states.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              init_busy,
    output logic              reset_req,
    output logic              shutdown_req,
    output logic              bad_access
);

    localparam int unsigned PTR_W = $clog2(NUM_WORDS);

    logic              in_range, is_cmd, is_status;
    logic [PTR_W-1:0]  word_ptr, seq_ptr, ram_addr;
    logic [31:0]       seq_value, ram_wdata, ram_q;
    logic              ram_en, ram_we;
    logic              accept, rd_accept;
    logic              force_q, oob_q;
    cmd_e              cmd;

    sysctl_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) decode_i (
        .addr      (bus_addr),
        .in_range  (in_range),
        .word_ptr  (word_ptr),
        .is_cmd    (is_cmd),
        .is_status (is_status)
    );

    sysctl_init_seq #(
        .NUM_WORDS (NUM_WORDS)
    ) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (init_busy),
        .ptr   (seq_ptr),
        .value (seq_value)
    );

    // Qualify bus requests; nothing is accepted during the fill.
    always_comb begin
        accept    = bus_valid && !init_busy;
        rd_accept = accept && !bus_write;
        cmd       = decode_cmd(bus_wdata);
    end

    // Steer the RAM port to the sequencer or to the bus.
    always_comb begin
        ram_en    = init_busy || (accept && in_range);
        ram_we    = init_busy || bus_write;
        ram_addr  = init_busy ? seq_ptr   : word_ptr;
        ram_wdata = init_busy ? seq_value : bus_wdata;
    end

    sysctl_word_ram #(
        .DEPTH (NUM_WORDS),
        .WIDTH (DATA_W)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    // Register the read qualifiers together with the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            oob_q   <= 1'b0;
        end else if (rd_accept) begin
            force_q <= is_status;
            oob_q   <= !in_range;
        end
    end

    // Form the read data: zero above the bank, forced bits at status words.
    always_comb begin
        if (oob_q)        bus_rdata = '0;
        else if (force_q) bus_rdata = ram_q | FORCE_MASK;
        else              bus_rdata = ram_q;
    end

    // Registered one-cycle request and bad-access pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
            bad_access   <= 1'b0;
        end else begin
            reset_req    <= accept && bus_write && is_cmd && (cmd == CMD_RESET);
            shutdown_req <= accept && bus_write && is_cmd && (cmd == CMD_SHUTDOWN);
            bad_access   <= accept && !in_range && !(bus_write && is_cmd);
        end
    end

endmodule

// File: rtl/sysctl_regs_chk.sv
// Module: sysctl_regs_chk
// Checker bound to sysctl_regs. It watches the port-level protocol each
// cycle, relating bus requests to the pulses and read data that follow.
// Assumes the same parameters as the bound instance.
module sysctl_regs_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              init_busy,
    input logic              reset_req,
    input logic              shutdown_req,
    input logic              bad_access
);

    logic [31:0] a32;
    logic        rd_ok, cmd_wr, oob, stat;

    // Request classification seen at the ports.
    always_comb begin
        a32    = 32'(bus_addr);
        rd_ok  = bus_valid && !bus_write && !init_busy;
        cmd_wr = bus_valid && bus_write && !init_busy && (a32 == 32'hF00);
        oob    = 32'(bus_addr[ADDR_W-1:2]) >= NUM_WORDS;
        stat   = (a32 == 32'h100) || (a32 == 32'h108) || (a32 == 32'h10C);
    end

    p_busy_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |=> !init_busy);

    p_busy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> (!reset_req && !shutdown_req && !bad_access));

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(bus_rdata));

    p_status_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && stat) |=> (bus_rdata[29:28] == 2'b11));

    p_reset_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(cmd_wr && (bus_wdata == 32'd1 || bus_wdata == 32'd2)));

    p_shutdown_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(cmd_wr && bus_wdata == 32'd3));

    p_cmd_not_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !bad_access);

    p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && oob) |=> (bus_rdata == 32'd0 && bad_access));

    p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && shutdown_req));

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .init_busy    (init_busy),
    .reset_req    (reset_req),
    .shutdown_req (shutdown_req),
    .bad_access   (bad_access)
);

// File: tb/sysctl_regs_tb_top.sv
`timescale 1ns/1ps
// Bench for sysctl_regs: a vector table followed by directed reset and
// corner-case tests. Inputs are driven at falling edges and outputs are
// sampled at the following falling edge.
module sysctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        init_busy, reset_req, shutdown_req, bad_access;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regs dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .init_busy    (init_busy),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req),
        .bad_access   (bad_access)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_rst;
        logic        exp_shd;
        logic        exp_bad;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h100, 32'h0,        1'b1, 32'h35F2_0121, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 12'h101, 32'h0,        1'b1, 32'h05F2_0121, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b0, 12'h104, 32'h0,        1'b1, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 4'd1}, // R1
        '{1'b0, 12'h108, 32'h0,        1'b1, 32'h35F3_0121, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 12'h10C, 32'h0,        1'b1, 32'h35F4_0121, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b1, 12'h010, 32'hDEADBEEF, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 12'h013, 32'h0,        1'b1, 32'hDEADBEEF,  1'b0, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b1, 12'h7FC, 32'h12345678, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 12'h7FC, 32'h0,        1'b1, 32'h12345678,  1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 12'h800, 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b1, 4'd9}, // R9
        '{1'b1, 12'h800, 32'hAAAA5555, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 4'd9}, // R9
        '{1'b0, 12'h000, 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd9}, // R9
        '{1'b1, 12'hF00, 32'd1,        1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, 12'hF00, 32'd2,        1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, 12'hF00, 32'd3,        1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 4'd7}, // R7
        '{1'b1, 12'hF00, 32'd4,        1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd8}, // R8
        '{1'b1, 12'hF00, 32'd0,        1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd8}, // R8
        '{1'b0, 12'hF00, 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b1, 4'd9}, // R9
        '{1'b1, 12'hF04, 32'd1,        1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 4'd8}, // R8
        '{1'b1, 12'h100, 32'h0,        1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 12'h100, 32'h0,        1'b1, 32'h3000_0000, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 12'h101, 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b1, 12'h108, 32'hFFFFFFFF, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 12'h108, 32'h0,        1'b1, 32'hFFFFFFFF,  1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b1, 12'hF01, 32'd1,        1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 4'd8}  // R8
    };

    // Record one comparison and report a mismatch.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Drive one bus access and sample the outputs one cycle later.
    task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] data,
                          output logic [31:0] rd, output logic rs, output logic sd,
                          output logic bad);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        rd  = bus_rdata;
        rs  = reset_req;
        sd  = shutdown_req;
        bad = bad_access;
    endtask

    task automatic wait_ready();
        while (init_busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(900_000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        rs, sd, bad;
        int          busy_cycles;
        string       tag;

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "busy in reset", 32'(init_busy), 32'd1);
        check("R3", "rdata in reset", bus_rdata, 32'd0);
        check("R10", "requests in reset", {29'd0, reset_req, shutdown_req, bad_access}, 32'd0);

        // R1: busy length after release
        rst_n = 1'b1;
        busy_cycles = 0;
        while (init_busy && busy_cycles < 2000) begin
            busy_cycles++;
            @(negedge clk);
        end
        check("R1", "busy cycles", 32'(busy_cycles), 32'd512);
        repeat (3) @(negedge clk);
        check("R1", "busy stays low", 32'(init_busy), 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d", VEC[i].req);
            access(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, rs, sd, bad);
            if (VEC[i].chk_rd) check(tag, $sformatf("rdata vec %0d", i), rd, VEC[i].exp_rd);
            check(tag, $sformatf("pulses vec %0d", i), {29'd0, rs, sd, bad},
                  {29'd0, VEC[i].exp_rst, VEC[i].exp_shd, VEC[i].exp_bad});
        end

        // R10: request pulse lasts one cycle
        access(1'b1, 12'hF00, 32'd2, rd, rs, sd, bad);
        check("R10", "reset pulse high", 32'(rs), 32'd1);
        @(negedge clk);
        check("R10", "reset pulse gone", 32'(reset_req), 32'd0);
        access(1'b1, 12'hF00, 32'd3, rd, rs, sd, bad);
        @(negedge clk);
        check("R10", "shutdown pulse gone", 32'(shutdown_req), 32'd0);

        // R3: read data held across a write and idle cycles
        access(1'b0, 12'h7FC, 32'h0, rd, rs, sd, bad);
        access(1'b1, 12'h7FC, 32'h0BAD0BAD, rd, rs, sd, bad);
        repeat (2) @(negedge clk);
        check("R3", "rdata held", bus_rdata, 32'h12345678);

        // R2: second reset, accesses during the fill are ignored
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 12'h014, 32'h0000FFFF, rd, rs, sd, bad);
        check("R2", "no pulse on busy write", {29'd0, rs, sd, bad}, 32'd0);
        access(1'b1, 12'hF00, 32'd1, rd, rs, sd, bad);
        check("R2", "no request on busy command", {29'd0, rs, sd, bad}, 32'd0);
        access(1'b0, 12'h800, 32'h0, rd, rs, sd, bad);
        check("R2", "no bad on busy read", 32'(bad), 32'd0);
        access(1'b0, 12'h100, 32'h0, rd, rs, sd, bad);
        check("R2", "rdata held while busy", rd, 32'd0);
        wait_ready();
        access(1'b0, 12'h014, 32'h0, rd, rs, sd, bad);
        check("R2", "busy write not stored", rd, 32'd0);

        // R1: values restored by the second reset
        access(1'b0, 12'h010, 32'h0, rd, rs, sd, bad);
        check("R1", "word 4 cleared", rd, 32'd0);
        access(1'b0, 12'h7FC, 32'h0, rd, rs, sd, bad);
        check("R1", "word 511 cleared", rd, 32'd0);
        access(1'b0, 12'h110, 32'h0, rd, rs, sd, bad);
        check("R1", "word 0x44 zero", rd, 32'd0);
        access(1'b0, 12'h109, 32'h0, rd, rs, sd, bad);
        check("R1", "word 0x42 raw", rd, 32'h05F3_0121);
        access(1'b0, 12'h100, 32'h0, rd, rs, sd, bad);
        check("R5", "word 0x40 forced", rd, 32'h35F2_0121);

        @(negedge clk);
        finish_run();
    end

endmodule